// File: doc/BRIEF.md
# Per-Stream PRBS Bit Error Tester

This block runs a bit error rate test over the channels of one byte-wide TDM stream. On the transmit side it replaces the payload of chosen timeslots with bytes of a 2^15-1 pseudo-random sequence. Timeslots that are not chosen pass their switched data through unchanged. On the receive side it compares the bytes of chosen timeslots with a locally generated copy of the same sequence. It adds every differing bit to a saturating error counter.

Each byte arrives with its timeslot index. A per-timeslot memory holds two enable bits for every slot, one for insertion and one for checking. The sequence steps only in enabled slots, so the test pattern continues across frames through the selected channels only. The receive checker finds the sequence phase by itself. Software reads the error counter and clears it through a plain read value and a clear strobe.

Top module: `ber_tester`

## Requirements
- R1: After reset the error count is 0, `rx_locked_o` is 0, `tx_valid_o` is 0, and every insertion and check enable is 0. With no slot enabled, transmit bytes pass through unchanged.
- R2: A cycle with `en_we_i` high writes `en_tx_i` and `en_rx_i` as the two enable bits of slot `en_slot_i`. The new enables govern bytes presented from the next cycle on.
- R3: A transmit byte in a slot whose insertion enable is set leaves as the next byte of the generator, one cycle later. The generator is x^15+x^14+1, with new bit = s[14] xor s[13] and the state shifted left taking in the new bit. It is seeded to all ones after reset, and each byte packs its 8 new bits first-generated into bit 7.
- R4: A transmit byte in a slot without insertion enable leaves unchanged one cycle later, and the generator does not advance. The next inserted byte continues the sequence where it stopped.
- R5: `tx_valid_o` equals `tx_valid_i` delayed by one cycle.
- R6: While unlocked, the checker shifts received bits into its 15-bit state, MSB of each byte first. It locks after 15 consecutive bits that each equal s[14] xor s[13] of the state before them. After that it runs free on its own prediction. Lock holds until reset and shows on `rx_locked_o` from the cycle after the byte that completed it.
- R7: Every bit of an enabled received byte that is processed while locked and differs from the prediction adds one to the counter, up to 8 per byte. The counter shows the sum one cycle after the byte.
- R8: Bytes in slots without check enable are ignored. The count does not change and the checker's sequence position does not advance.
- R9: The 16-bit counter saturates at 65535 and stays there under further errors.
- R10: `err_clr_i` clears the counter. When it coincides with an errored enabled byte, the counter takes that byte's error count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_we_i | input | 1 | Enable memory write strobe |
| en_slot_i | input | 7 | Timeslot written |
| en_tx_i | input | 1 | Insertion enable value |
| en_rx_i | input | 1 | Check enable value |
| tx_valid_i | input | 1 | Transmit byte present |
| tx_slot_i | input | 7 | Timeslot of transmit byte |
| tx_data_i | input | 8 | Switched transmit data |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_data_o | output | 8 | Outgoing byte |
| rx_valid_i | input | 1 | Received byte present |
| rx_slot_i | input | 7 | Timeslot of received byte |
| rx_data_i | input | 8 | Received data |
| rx_locked_o | output | 1 | Checker synchronised |
| err_clr_i | input | 1 | Counter clear strobe |
| err_cnt_o | output | 16 | Bit error count |

## Verification
Two functions meet in one cycle: a software clear of the counter and the accumulation of an errored received byte. The bench first builds a non-zero count. It then presents an enabled byte with three flipped bits in the same cycle as the clear strobe, and expects a count of exactly three rather than zero or the old sum plus three. A second collision is saturation against further errors: after 8192 fully inverted bytes the count must sit at 65535 and stay there for one more errored byte.

// File: rtl/ber_pkg.sv
package ber_pkg;
  localparam int PRBS_W = 15;

  typedef struct packed {
    logic [PRBS_W-1:0] st;
    logic [7:0]        dat;
  } prbs_step_t;

  // advance x^15+x^14+1 by eight bits, first bit into bit 7
  function automatic prbs_step_t prbs_byte(input logic [PRBS_W-1:0] s);
    prbs_step_t r;
    logic nb;
    r.st = s;
    r.dat = '0;
    for (int i = 7; i >= 0; i--) begin
      nb = r.st[14] ^ r.st[13];
      r.dat[i] = nb;
      r.st = {r.st[13:0], nb};
    end
    return r;
  endfunction
endpackage

// File: rtl/ber_en_mem.sv
module ber_en_mem #(
  parameter int NUM_SLOTS = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] waddr_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic [SLOT_W-1:0] tx_raddr_i,
  input  logic [SLOT_W-1:0] rx_raddr_i,
  output logic              tx_hit_o,
  output logic              rx_hit_o
);
  logic [NUM_SLOTS-1:0] tx_en_q, rx_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= '0;
      rx_en_q <= '0;
    end else if (we_i) begin
      tx_en_q[waddr_i] <= tx_en_i;
      rx_en_q[waddr_i] <= rx_en_i;
    end
  end

  assign tx_hit_o = tx_en_q[tx_raddr_i];
  assign rx_hit_o = rx_en_q[rx_raddr_i];

  AST_EN_WRITE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tx_en_q[$past(waddr_i)] == $past(tx_en_i)); // R2
  AST_EN_WRITE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rx_en_q[$past(waddr_i)] == $past(rx_en_i)); // R2
endmodule

// File: rtl/ber_prbs_gen.sv
module ber_prbs_gen
  import ber_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  output logic [7:0] dat_o
);
  logic [PRBS_W-1:0] st_q;
  prbs_step_t        nxt;

  assign nxt   = prbs_byte(st_q);
  assign dat_o = nxt.dat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '1;
    else if (adv_i) st_q <= nxt.st;
  end

  AST_GEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(st_q)); // R4
  AST_GEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0); // R3
endmodule

// File: rtl/ber_prbs_chk.sv
module ber_prbs_chk
  import ber_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] dat_i,
  output logic       locked_o,
  output logic [3:0] err_n_o
);
  logic [PRBS_W-1:0] st_q, st_d;
  logic [3:0]        good_q, good_d;
  logic              lock_q, lock_d;
  logic [3:0]        nerr;

  always_comb begin
    logic b, e;
    st_d   = st_q;
    good_d = good_q;
    lock_d = lock_q;
    nerr   = '0;
    for (int i = 7; i >= 0; i--) begin
      b = dat_i[i];
      e = st_d[14] ^ st_d[13];
      if (lock_d) begin
        if (b != e) nerr = nerr + 4'd1;
        st_d = {st_d[13:0], e};
      end else begin
        good_d = (b == e) ? good_d + 4'd1 : 4'd0;
        st_d   = {st_d[13:0], b};
        if (good_d == 4'd15) lock_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (valid_i) begin
      st_q   <= st_d;
      good_q <= good_d;
      lock_q <= lock_d;
    end
  end

  assign locked_o = lock_q;
  assign err_n_o  = valid_i ? nerr : 4'd0;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R6
  AST_ERR_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_n_o != 4'd0) |=> lock_q); // R7
  AST_CHK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(st_q)); // R8
endmodule

// File: rtl/ber_err_cnt.sv
module ber_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [3:0]       add_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q, base;
  logic [CNT_W:0]   sum;

  assign base = clr_i ? '0 : cnt_q;
  assign sum  = {1'b0, base} + {{(CNT_W-3){1'b0}}, add_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (sum[CNT_W]) cnt_q <= CNT_MAX;
    else             cnt_q <= sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX); // R9
  AST_NO_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q >= $past(cnt_q)); // R7
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && add_i == 4'd0) |=> cnt_q == '0); // R10
endmodule

// File: rtl/ber_tester.sv
module ber_tester #(
  parameter int NUM_SLOTS = 128,
  parameter int CNT_W     = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic [SLOT_W-1:0] en_slot_i,
  input  logic              en_tx_i,
  input  logic              en_rx_i,
  input  logic              tx_valid_i,
  input  logic [SLOT_W-1:0] tx_slot_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              rx_valid_i,
  input  logic [SLOT_W-1:0] rx_slot_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_locked_o,
  input  logic              err_clr_i,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic       tx_hit, rx_hit, tx_ins, rx_chk;
  logic [7:0] gen_dat;
  logic [3:0] err_n;

  ber_en_mem #(.NUM_SLOTS(NUM_SLOTS)) u_en_mem (
    .clk_i, .rst_ni,
    .we_i(en_we_i), .waddr_i(en_slot_i), .tx_en_i(en_tx_i), .rx_en_i(en_rx_i),
    .tx_raddr_i(tx_slot_i), .rx_raddr_i(rx_slot_i),
    .tx_hit_o(tx_hit), .rx_hit_o(rx_hit)
  );

  assign tx_ins = tx_valid_i && tx_hit;
  assign rx_chk = rx_valid_i && rx_hit;

  ber_prbs_gen u_gen (
    .clk_i, .rst_ni, .adv_i(tx_ins), .dat_o(gen_dat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= tx_valid_i;
      if (tx_valid_i) tx_data_o <= tx_hit ? gen_dat : tx_data_i;
    end
  end

  ber_prbs_chk u_chk (
    .clk_i, .rst_ni, .valid_i(rx_chk), .dat_i(rx_data_i),
    .locked_o(rx_locked_o), .err_n_o(err_n)
  );

  ber_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(err_clr_i), .add_i(err_n), .cnt_o(err_cnt_o)
  );

  AST_TX_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o == $past(tx_valid_i)); // R5
  AST_TX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_hit) |=> tx_data_o == $past(tx_data_i)); // R4
  AST_RX_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_chk && !err_clr_i) |=> $stable(err_cnt_o)); // R8
endmodule

// File: tb/ber_tester_bench.sv
module ber_tester_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_we = 1'b0, en_tx = 1'b0, en_rx = 1'b0;
  logic [6:0] en_slot = '0, tx_slot = '0, rx_slot = '0;
  logic       tx_valid = 1'b0, rx_valid = 1'b0, err_clr = 1'b0;
  logic [7:0] tx_data = '0, rx_data = '0;
  logic       tx_valid_o, rx_locked;
  logic [7:0] tx_data_o;
  logic [15:0] err_cnt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];
  bit tb_tx_en[128];
  bit tb_rx_en[128];
  logic [14:0] tx_st = 15'h7fff;
  logic [14:0] rx_st = 15'h7fff;

  always #(CLK_PERIOD/2) clk = ~clk;

  ber_tester u_ber_tester (
    .clk_i(clk), .rst_ni(rst_n),
    .en_we_i(en_we), .en_slot_i(en_slot), .en_tx_i(en_tx), .en_rx_i(en_rx),
    .tx_valid_i(tx_valid), .tx_slot_i(tx_slot), .tx_data_i(tx_data),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid), .rx_slot_i(rx_slot), .rx_data_i(rx_data),
    .rx_locked_o(rx_locked), .err_clr_i(err_clr), .err_cnt_o(err_cnt)
  );

  // returns {next_state, byte}
  function automatic logic [22:0] seq_byte(input logic [14:0] s);
    logic [7:0] d;
    logic f;
    for (int k = 0; k < 8; k++) begin
      f = s[14] ^ s[13];
      d = {d[6:0], f};
      s = {s[13:0], f};
    end
    return {s, d};
  endfunction

  function automatic int popc(input logic [7:0] v);
    int c = 0;
    for (int k = 0; k < 8; k++) c += int'(v[k]);
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_en(input int slot, input bit t, input bit r);
    @(negedge clk);
    en_we = 1; en_slot = 7'(slot); en_tx = t; en_rx = r;
    tb_tx_en[slot] = t; tb_rx_en[slot] = r;
    @(negedge clk);
    en_we = 0;
  endtask

  task automatic tx_send(input int slot, input logic [7:0] d, input string req);
    logic [22:0] r;
    @(negedge clk);
    tx_valid = 1; tx_slot = 7'(slot); tx_data = d;
    if (tb_tx_en[slot]) begin
      r = seq_byte(tx_st);
      tx_st = r[22:8];
      exp_q.push_back(r[7:0]);
    end else exp_q.push_back(d);
    req_q.push_back(req);
    @(negedge clk);
    tx_valid = 0;
  endtask

  // flip: bits to invert relative to the expected sequence byte
  task automatic rx_send(input int slot, input logic [7:0] flip, input bit clr);
    logic [22:0] r;
    @(negedge clk);
    rx_valid = 1; rx_slot = 7'(slot); err_clr = clr;
    if (tb_rx_en[slot]) begin
      r = seq_byte(rx_st);
      rx_st = r[22:8];
      rx_data = r[7:0] ^ flip;
    end else rx_data = flip;
    @(negedge clk);
    rx_valid = 0; err_clr = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid_o) begin
      if (exp_q.size() == 0) check("R5", 1, 0);
      else begin
        logic [7:0] e;
        string rq;
        e = exp_q.pop_front();
        rq = req_q.pop_front();
        check(rq, int'(tx_data_o), int'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", int'(err_cnt), 0);
    check("R1 lock", int'(rx_locked), 0);
    check("R1 valid", int'(tx_valid_o), 0);
    tx_send(5, 8'h3c, "R1 passthrough");
    // R3/R4 insertion in slots 2 and 9 across two frames
    wr_en(2, 1, 0);
    wr_en(9, 1, 1);
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 12; s++)
        tx_send(s, 8'(s * 17 + f), (s == 2 || s == 9) ? "R3" : "R4");
    // R2 disable slot 2, enable slot 4
    wr_en(2, 0, 0);
    wr_en(4, 1, 0);
    for (int s = 0; s < 12; s++) tx_send(s, 8'(s + 100), "R2");
    @(negedge clk);
    check("R5 drained", exp_q.size(), 0);

    // R6 sync on clean sequence in slot 9
    rx_send(9, 8'h00, 0);
    check("R6 not locked early", int'(rx_locked), 0);
    for (int k = 0; k < 3; k++) rx_send(9, 8'h00, 0);
    check("R6 locked", int'(rx_locked), 1);
    check("R6 no errors", int'(err_cnt), 0);
    // R7 errors
    rx_send(9, 8'h05, 0);
    check("R7 two bits", int'(err_cnt), 2);
    rx_send(9, 8'hff, 0);
    check("R7 eight bits", int'(err_cnt), 10);
    // R8 disabled slot ignored, sequence position kept
    rx_send(3, 8'hff, 0);
    check("R8 count held", int'(err_cnt), 10);
    rx_send(9, 8'h00, 0);
    check("R8 position kept", int'(err_cnt), 10);
    // R10 clear alone and coincident
    rx_send(3, 8'h00, 1);
    check("R10 clear", int'(err_cnt), 0);
    rx_send(9, 8'h81, 0);
    rx_send(9, 8'h70, 1);
    check("R10 clear with errors", int'(err_cnt), popc(8'h70));
    // R9 saturation
    for (int k = 0; k < 8192; k++) rx_send(9, 8'hff, 0);
    check("R9 saturated", int'(err_cnt), 65535);
    rx_send(9, 8'hff, 0);
    check("R9 held", int'(err_cnt), 65535);
    check("R6 lock sticky", int'(rx_locked), 1);
    rx_send(9, 8'h00, 1);
    check("R10 clear after saturation", int'(err_cnt), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule